// File: doc/BRIEF.md
# Microcontroller Bus Interface Unit

This unit sits between a microcontroller bus and a peripheral. It takes either a shared address/data bus, where the low address byte must be held from the address phase, or a bus with separate address lines. In shared-bus mode a clocked latch captures the low byte whenever the address strobe is active. The strobe's active level is set by configuration. The high address lines always pass straight through. A 4-bit page register sits above the bus address and widens the reachable space sixteen-fold.

A second, polarity-configurable reset input clears the bus-side state synchronously. The asynchronous core reset remains separate. The unit also watches the strobe for transitions. When none has occurred for a programmed number of clocks, it raises a power-down request. Any new transition drops that request again.

Top module: `mcu_bus_adapter`

## Requirements
- R1: While rst_ni is low, the page register, the captured low byte and the idle counter are cleared, and pdn_o is 0.
- R2: With cfg_mux_i=1, a clock edge at which the strobe is active loads ad_i into the low byte. The value appears on addr_o[7:0] after that edge. At edges where the strobe is inactive, the low byte holds.
- R3: With cfg_ale_pol_i=1 the strobe ale_i is active when high. With cfg_ale_pol_i=0 it is active when low.
- R4: With cfg_mux_i=0, addr_o[7:0] equals ad_i combinationally, whatever ale_i does.
- R5: addr_o[15:8] always equals addr_hi_i.
- R6: A clock edge with page_we_i=1 loads page_d_i into the page register. page_addr_o is {page, addr_o}, with the page in bits 19:16.
- R7: The bus reset is asserted when bus_rst_i equals cfg_rst_pol_i. At each clock edge where it is asserted, it clears the page register, the captured low byte and the idle counter, and sets pdn_o to 0. It takes priority over loads.
- R8: An edge of ale_i is a clock edge at which ale_i differs from its value at the previous edge. After the clock edge that detects an edge of ale_i, pdn_o stays 0 for idle_limit_i further clock edges and becomes 1 after the next one. With a limit of 0, it becomes 1 at the first clock edge after the detecting edge.
- R9: The clock edge that detects an edge of ale_i sets pdn_o to 0. pdn_o stays 1 while no such edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low core reset |
| cfg_mux_i | input | 1 | 1: shared address/data bus, 0: separate address bus |
| cfg_ale_pol_i | input | 1 | Strobe active level |
| cfg_rst_pol_i | input | 1 | Bus reset active level |
| bus_rst_i | input | 1 | Bus reset input |
| ale_i | input | 1 | Address latch strobe |
| ad_i | input | 8 | Shared bus or low address lines |
| addr_hi_i | input | 8 | High address lines |
| page_we_i | input | 1 | Page register write strobe |
| page_d_i | input | 4 | Page register write data |
| idle_limit_i | input | 16 | Idle clock count before power-down |
| addr_o | output | 16 | Full bus address |
| page_addr_o | output | 20 | Page-extended address |
| pdn_o | output | 1 | Power-down request |

## Verification
The bench builds the unit with its default widths: an 8-bit low byte, a 16-bit address, a 4-bit page and a 16-bit idle counter. The idle limit is a port, so the wide counter costs no simulation time. Limits of 0 and 5 put both the immediate case and the counted power-down boundary within a few clocks. The 4-bit page lets the bench write the all-ones and mixed page values that cover every bit of the extended address.

// File: rtl/mba_pkg.sv
package mba_pkg;
  typedef enum logic {BUS_SPLIT = 1'b0, BUS_MUX = 1'b1} bus_mode_e;

  function automatic logic level_active(input logic sig, input logic pol);
    return sig == pol;
  endfunction
endpackage

// File: rtl/addr_capture.sv
module addr_capture #(
  parameter int unsigned LO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            mux_i,
  input  logic            active_i,
  input  logic [LO_W-1:0] ad_i,
  output logic [LO_W-1:0] lo_o
);
  import mba_pkg::*;
  logic [LO_W-1:0] lo_q;
  bus_mode_e mode;

  assign mode = bus_mode_e'(mux_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             lo_q <= '0;
    else if (clr_i)                          lo_q <= '0;
    else if (mode == BUS_MUX && active_i)    lo_q <= ad_i;
  end

  // separate bus: transparent path
  assign lo_o = (mode == BUS_MUX) ? lo_q : ad_i;
endmodule

// File: rtl/page_reg.sv
module page_reg #(
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] d_i,
  output logic [PAGE_W-1:0] page_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    page_o <= '0;
    else if (clr_i) page_o <= '0;
    else if (we_i)  page_o <= d_i;
  end
endmodule

// File: rtl/idle_monitor.sv
module idle_monitor #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             pdn_o
);
  logic             strobe_q;
  logic             edge_det;
  logic [CNT_W-1:0] cnt_q;

  assign edge_det = strobe_i ^ strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      cnt_q    <= '0;
      pdn_o    <= 1'b0;
    end else begin
      strobe_q <= strobe_i;
      if (clr_i || edge_det) begin
        cnt_q <= '0;
        pdn_o <= 1'b0;
      end else if (cnt_q >= limit_i) begin
        // saturate; >= covers a limit lowered mid-count
        pdn_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcu_bus_adapter.sv
module mcu_bus_adapter #(
  parameter int unsigned LO_W   = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned HI_W  = ADDR_W - LO_W,
  localparam int unsigned EXT_W = ADDR_W + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_mux_i,
  input  logic              cfg_ale_pol_i,
  input  logic              cfg_rst_pol_i,
  input  logic              bus_rst_i,
  input  logic              ale_i,
  input  logic [LO_W-1:0]   ad_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic              page_we_i,
  input  logic [PAGE_W-1:0] page_d_i,
  input  logic [CNT_W-1:0]  idle_limit_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [EXT_W-1:0]  page_addr_o,
  output logic              pdn_o
);
  import mba_pkg::*;

  logic              bus_clr;
  logic              ale_act;
  logic [LO_W-1:0]   lo_addr;
  logic [PAGE_W-1:0] page;

  assign bus_clr = level_active(bus_rst_i, cfg_rst_pol_i);
  assign ale_act = level_active(ale_i, cfg_ale_pol_i);

  addr_capture #(.LO_W(LO_W)) i_addr_capture (
    .clk_i, .rst_ni, .clr_i(bus_clr), .mux_i(cfg_mux_i),
    .active_i(ale_act), .ad_i, .lo_o(lo_addr)
  );

  page_reg #(.PAGE_W(PAGE_W)) i_page_reg (
    .clk_i, .rst_ni, .clr_i(bus_clr), .we_i(page_we_i),
    .d_i(page_d_i), .page_o(page)
  );

  idle_monitor #(.CNT_W(CNT_W)) i_idle_monitor (
    .clk_i, .rst_ni, .clr_i(bus_clr), .strobe_i(ale_i),
    .limit_i(idle_limit_i), .pdn_o
  );

  assign addr_o      = {addr_hi_i, lo_addr};
  assign page_addr_o = {page, addr_o};
endmodule

// File: rtl/mcu_bus_adapter_chk.sv
module mcu_bus_adapter_chk #(
  parameter int unsigned LO_W   = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 4,
  localparam int unsigned EXT_W = ADDR_W + PAGE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_mux_i,
  input logic              cfg_ale_pol_i,
  input logic              cfg_rst_pol_i,
  input logic              bus_rst_i,
  input logic              ale_i,
  input logic [LO_W-1:0]   ad_i,
  input logic              page_we_i,
  input logic [PAGE_W-1:0] page_d_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [EXT_W-1:0]  page_addr_o,
  input logic              pdn_o
);
  logic brst;
  logic seen;
  assign brst = (bus_rst_i == cfg_rst_pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> !pdn_o);

  p_edge_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && ale_i != $past(ale_i)) |=> !pdn_o);

  p_pdn_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && pdn_o && ale_i == $past(ale_i) && !brst) |=> pdn_o);

  p_page_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_we_i && !brst) |=> page_addr_o[EXT_W-1:ADDR_W] == $past(page_d_i));

  p_bus_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brst |=> (!pdn_o && page_addr_o[EXT_W-1:ADDR_W] == '0));

  p_latch_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mux_i && ale_i != cfg_ale_pol_i && !brst)
      |=> (!cfg_mux_i || $stable(addr_o[LO_W-1:0])));

  p_split_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mux_i |-> addr_o[LO_W-1:0] == ad_i);
endmodule

bind mcu_bus_adapter mcu_bus_adapter_chk #(
  .LO_W(LO_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)
) i_chk (
  .clk_i, .rst_ni, .cfg_mux_i, .cfg_ale_pol_i, .cfg_rst_pol_i, .bus_rst_i,
  .ale_i, .ad_i, .page_we_i, .page_d_i, .addr_o, .page_addr_o, .pdn_o
);

// File: tb/test_mcu_bus_adapter.sv
module test_mcu_bus_adapter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_mux_i = 1'b1;
  logic        cfg_ale_pol_i = 1'b1;
  logic        cfg_rst_pol_i = 1'b1;
  logic        bus_rst_i = 1'b0;
  logic        ale_i = 1'b0;
  logic [7:0]  ad_i = 8'h00;
  logic [7:0]  addr_hi_i = 8'h00;
  logic        page_we_i = 1'b0;
  logic [3:0]  page_d_i = 4'h0;
  logic [15:0] idle_limit_i = 16'd1000;
  logic [15:0] addr_o;
  logic [19:0] page_addr_o;
  logic        pdn_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mcu_bus_adapter i_mcu_bus_adapter (
    .clk_i, .rst_ni, .cfg_mux_i, .cfg_ale_pol_i, .cfg_rst_pol_i, .bus_rst_i,
    .ale_i, .ad_i, .addr_hi_i, .page_we_i, .page_d_i, .idle_limit_i,
    .addr_o, .page_addr_o, .pdn_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #1;
    check("R1 pdn", 32'(pdn_o), 0);
    check("R1 page_addr", 32'(page_addr_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_mux_high();  // R2, R3, R5
    cfg_mux_i = 1; cfg_ale_pol_i = 1;
    @(negedge clk_i); addr_hi_i = 8'hA7; ad_i = 8'h5A; ale_i = 1;
    @(negedge clk_i);
    check("R2 capture", 32'(addr_o), 32'hA75A);
    ale_i = 0; ad_i = 8'h33;
    @(negedge clk_i);
    check("R2 hold", 32'(addr_o), 32'hA75A);
    addr_hi_i = 8'h12; #1;
    check("R5 hi pass", 32'(addr_o[15:8]), 32'h12);
  endtask

  task automatic t_mux_low();  // R3
    @(negedge clk_i); cfg_ale_pol_i = 0; ale_i = 1; ad_i = 8'hC1;
    @(negedge clk_i);
    check("R3 low-pol inactive when high", 32'(addr_o[7:0]), 32'h5A);
    ale_i = 0;
    @(negedge clk_i);
    check("R3 low-pol capture", 32'(addr_o[7:0]), 32'hC1);
    ale_i = 1; ad_i = 8'h44;
    @(negedge clk_i);
    check("R3 low-pol hold", 32'(addr_o[7:0]), 32'hC1);
  endtask

  task automatic t_split();  // R4
    @(negedge clk_i); cfg_mux_i = 0; ad_i = 8'h9E; #1;
    check("R4 pass", 32'(addr_o[7:0]), 32'h9E);
    ale_i = ~ale_i; ad_i = 8'h21; #1;
    check("R4 strobe ignored", 32'(addr_o[7:0]), 32'h21);
    @(negedge clk_i);
    check("R4 after edge", 32'(addr_o[7:0]), 32'h21);
    cfg_mux_i = 1;
  endtask

  task automatic t_page();  // R6
    @(negedge clk_i); page_d_i = 4'hF; page_we_i = 1;
    @(negedge clk_i); page_we_i = 0; page_d_i = 4'h0;
    check("R6 page F", 32'(page_addr_o[19:16]), 32'hF);
    check("R6 ext addr", 32'(page_addr_o[15:0]), 32'(addr_o));
    page_d_i = 4'h6;
    @(negedge clk_i);
    check("R6 no write", 32'(page_addr_o[19:16]), 32'hF);
    page_we_i = 1;
    @(negedge clk_i); page_we_i = 0;
    check("R6 page 6", 32'(page_addr_o[19:16]), 32'h6);
  endtask

  task automatic t_bus_reset(input logic pol);  // R7
    @(negedge clk_i);
    cfg_rst_pol_i = pol; bus_rst_i = ~pol;
    cfg_ale_pol_i = 1; ale_i = 1; ad_i = 8'h77;
    page_d_i = 4'h9; page_we_i = 1;
    @(negedge clk_i);
    check("R7 pre page", 32'(page_addr_o[19:16]), 32'h9);
    ale_i = 0; page_we_i = 0;
    @(negedge clk_i);
    bus_rst_i = pol; page_we_i = 1; page_d_i = 4'h3;
    @(negedge clk_i);
    bus_rst_i = ~pol; page_we_i = 0;
    check("R7 page clr", 32'(page_addr_o[19:16]), 0);
    check("R7 lo clr", 32'(addr_o[7:0]), 0);
    check("R7 pdn clr", 32'(pdn_o), 0);
  endtask

  task automatic t_idle(input int lim);  // R8, R9
    @(negedge clk_i); idle_limit_i = 16'(lim); ale_i = ~ale_i;
    @(posedge clk_i);
    repeat (lim) @(posedge clk_i);
    @(negedge clk_i);
    check($sformatf("R8 pdn low at limit %0d", lim), 32'(pdn_o), 0);
    @(negedge clk_i);
    check($sformatf("R8 pdn high after limit %0d", lim), 32'(pdn_o), 1);
    @(negedge clk_i);
    check("R9 pdn stays", 32'(pdn_o), 1);
    ale_i = ~ale_i;
    @(negedge clk_i);
    check("R9 wake clears", 32'(pdn_o), 0);
  endtask

  initial begin
    t_reset();
    t_mux_high();
    t_mux_low();
    t_split();
    t_page();
    t_bus_reset(1'b1);
    t_bus_reset(1'b0);
    cfg_rst_pol_i = 1; bus_rst_i = 0;
    t_idle(5);
    t_idle(0);
    t_idle(2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule